// File: doc/BRIEF.md
# Big-Endian Load Data Formatter

This block sits between the load issue point of a 32-bit integer pipeline, a big-endian data memory read port and the register file write ports. A load request carries a base register value, a signed 16-bit displacement, an access size, an extension mode and an update flag. The block adds the displacement to the base to form the effective address. For a legal request it issues a word-aligned memory read in the same cycle. One cycle later it picks the addressed byte, halfword or word out of the returned word in big-endian lane order. It then zero-extends or sign-extends that value to 32 bits and presents it as a register write.

In update mode the block also writes the effective address back into the base register, in the same cycle as the data write. Some requests are rejected before any memory access. These are malformed combinations (a sign-extending byte or word load, a reserved size code, or an update load whose base register is register 0 or equals the destination) and misaligned halfword or word addresses. A rejected request raises a registered fault code one cycle later and performs no register write.

Top module: `ldf_load_formatter`

## Requirements
- R1: The effective address is the base value plus the displacement sign-extended to 32 bits. For a legal request, `mem_rd_en` is high in the request cycle and `mem_addr` is the effective address with its two low bits forced to zero.
- R2: Size code 0 (byte) with sign 0 returns the byte at effective-address offset k within the word. That byte is taken from `mem_rdata` bits [31-8k:24-8k], so offset 0 is the most significant byte. The byte goes in bits 7..0 and bits 31..8 are zero.
- R3: Size code 1 (halfword) with sign 0 returns the halfword at even offset k, taken from `mem_rdata` bits [31-8k:16-8k], in bits 15..0. Bits 31..16 are zero.
- R4: Size code 1 with sign 1 returns the same halfword in bits 15..0. Bits 31..16 are copies of the halfword's bit 15.
- R5: Size code 2 (word) with sign 0 returns all 32 bits of `mem_rdata` unchanged.
- R6: A request with sign 1 and size code 0 or 2 is rejected with fault code 1. It issues no memory read and makes no register write.
- R7: Size code 3 is reserved. Such a request is rejected with fault code 1, with no memory read and no register write.
- R8: With `req_update` set, a legal load writes the data to `req_rd`. In the same cycle it writes the effective address to register `req_ra` through `upd_en`/`upd_idx`/`upd_data`.
- R9: An update request whose `req_ra` is 0, or equals `req_rd`, is rejected with fault code 1 and makes no write.
- R10: A halfword with effective-address bit 0 set, or a word with either of bits 1..0 set, is rejected with fault code 2 and makes no memory read or write. When a request is both malformed and misaligned, fault code 1 takes priority.
- R11: `wb_en`, `upd_en` and `flt_valid` are high for exactly the one cycle after the accepted request, and back-to-back requests give back-to-back results. After reset all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request present this cycle |
| req_base | input | 32 | Base register contents |
| req_disp | input | 16 | Signed displacement |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_sign | input | 1 | 1 selects sign extension |
| req_update | input | 1 | 1 writes the effective address back to the base register |
| req_rd | input | 5 | Destination register index |
| req_ra | input | 5 | Base register index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| wb_en | output | 1 | Destination write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Formatted load data |
| upd_en | output | 1 | Base register write enable |
| upd_idx | output | 5 | Base register index |
| upd_data | output | 32 | Effective address |
| flt_valid | output | 1 | Rejected request indicator |
| flt_code | output | 2 | 1 malformed, 2 misaligned |

## Verification
The assertions take for granted that `mem_rdata` returns defined data in the cycle after every read strobe. The formatted-value properties look at `wb_data`, which is only meaningful then. They also assume request fields carry no unknown bits while `req_valid` is high. The bench models memory as a function of the byte address, answers every read one cycle later, and holds all request inputs at known values throughout.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_FORM  = 2'd1,
    FLT_ALIGN = 2'd2
  } ld_fault_e;
endpackage

// File: rtl/ldf_agen.sv
module ldf_agen
  import ldf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic [XLEN-1:0]   base,
  input  logic [DISP_W-1:0] disp,
  input  ld_size_e          size,
  input  logic              sign,
  input  logic              update,
  input  logic [IDX_W-1:0]  rd,
  input  logic [IDX_W-1:0]  ra,
  output logic [XLEN-1:0]   ea,
  output logic              form_bad,
  output logic              align_bad
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  function automatic logic [XLEN-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic shape_illegal(input ld_size_e s, input logic sg,
                                         input logic up, input logic [IDX_W-1:0] d,
                                         input logic [IDX_W-1:0] b);
    logic bad;
    bad = (s == SZ_RSVD);
    if (sg && (s != SZ_HALF)) bad = 1'b1;
    if (up && ((b == '0) || (b == d))) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic misaligned(input ld_size_e s, input logic [OW-1:0] lo);
    case (s)
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    ea        = base + widen_disp(disp);
    form_bad  = shape_illegal(size, sign, update, rd, ra);
    align_bad = misaligned(size, ea[OW-1:0]);
  end
endmodule

// File: rtl/ldf_extract.sv
module ldf_extract
  import ldf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]          rdata,
  input  logic [$clog2(XLEN/8)-1:0] ofs,
  input  ld_size_e                 size,
  input  logic                     sign,
  output logic [XLEN-1:0]          data
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  logic [7:0]  lane [NB];
  logic [7:0]  b_sel;
  logic [15:0] h_sel;

  // Lowest address occupies the most significant lane.
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane[k] = rdata[XLEN-1-8*k -: 8];
  end

  function automatic logic [XLEN-1:0] extend16(input logic [15:0] h, input logic sg);
    return {{(XLEN-16){sg & h[15]}}, h};
  endfunction

  always_comb begin
    b_sel = lane[ofs];
    h_sel = {lane[ofs], lane[ofs | OW'(1)]};
    case (size)
      SZ_BYTE: data = {{(XLEN-8){1'b0}}, b_sel};
      SZ_HALF: data = extend16(h_sel, sign);
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/ldf_stage.sv
module ldf_stage
  import ldf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5,
  parameter int OW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  ld_fault_e        fault_in,
  input  logic             upd_in,
  input  ld_size_e         size_in,
  input  logic             sign_in,
  input  logic [IDX_W-1:0] rd_in,
  input  logic [IDX_W-1:0] ra_in,
  input  logic [XLEN-1:0]  ea_in,
  output logic             st_issue,
  output logic             st_upd,
  output logic [OW-1:0]    st_ofs,
  output ld_size_e         st_size,
  output logic             st_sign,
  output logic [IDX_W-1:0] st_rd,
  output logic [IDX_W-1:0] st_ra,
  output logic [XLEN-1:0]  st_ea,
  output ld_fault_e        st_fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_issue <= 1'b0;
      st_upd   <= 1'b0;
      st_ofs   <= '0;
      st_size  <= SZ_BYTE;
      st_sign  <= 1'b0;
      st_rd    <= '0;
      st_ra    <= '0;
      st_ea    <= '0;
      st_fault <= FLT_NONE;
    end else begin
      st_issue <= issue;
      st_upd   <= issue & upd_in;
      st_fault <= fault_in;
      if (issue) begin
        st_ofs  <= ea_in[OW-1:0];
        st_size <= size_in;
        st_sign <= sign_in;
        st_rd   <= rd_in;
        st_ra   <= ra_in;
        st_ea   <= ea_in;
      end
    end
  end

  a_r6_fault_excludes_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fault != FLT_NONE) |-> !st_issue);
endmodule

// File: rtl/ldf_load_formatter.sv
module ldf_load_formatter
  import ldf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [XLEN-1:0]   req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [1:0]        req_size,
  input  logic              req_sign,
  input  logic              req_update,
  input  logic [IDX_W-1:0]  req_rd,
  input  logic [IDX_W-1:0]  req_ra,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [XLEN-1:0]   upd_data,
  output logic              flt_valid,
  output logic [1:0]        flt_code
);
  localparam int NB = XLEN / 8;
  localparam int OW = $clog2(NB);

  ld_size_e         size_in;
  logic [XLEN-1:0]  ea;
  logic             form_bad, align_bad;
  logic             issue_ok;
  ld_fault_e        fault_now;

  logic             st_issue, st_upd, st_sign;
  logic [OW-1:0]    st_ofs;
  ld_size_e         st_size;
  logic [IDX_W-1:0] st_rd, st_ra;
  logic [XLEN-1:0]  st_ea;
  ld_fault_e        st_fault;
  logic [XLEN-1:0]  fmt_data;

  assign size_in = ld_size_e'(req_size);

  ldf_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)) agen_i (
    .base(req_base), .disp(req_disp), .size(size_in), .sign(req_sign),
    .update(req_update), .rd(req_rd), .ra(req_ra),
    .ea(ea), .form_bad(form_bad), .align_bad(align_bad)
  );

  // Named events: the accepted issue and the fault class of this request.
  assign issue_ok  = req_valid & ~form_bad & ~align_bad;
  always_comb begin
    fault_now = FLT_NONE;
    if (req_valid && form_bad)       fault_now = FLT_FORM;
    else if (req_valid && align_bad) fault_now = FLT_ALIGN;
  end

  assign mem_rd_en = issue_ok;
  assign mem_addr  = {ea[XLEN-1:OW], {OW{1'b0}}};

  ldf_stage #(.XLEN(XLEN), .IDX_W(IDX_W), .OW(OW)) stage_i (
    .clk(clk), .rst_n(rst_n), .issue(issue_ok), .fault_in(fault_now),
    .upd_in(req_update), .size_in(size_in), .sign_in(req_sign),
    .rd_in(req_rd), .ra_in(req_ra), .ea_in(ea),
    .st_issue(st_issue), .st_upd(st_upd), .st_ofs(st_ofs), .st_size(st_size),
    .st_sign(st_sign), .st_rd(st_rd), .st_ra(st_ra), .st_ea(st_ea),
    .st_fault(st_fault)
  );

  ldf_extract #(.XLEN(XLEN)) extract_i (
    .rdata(mem_rdata), .ofs(st_ofs), .size(st_size), .sign(st_sign),
    .data(fmt_data)
  );

  assign wb_en     = st_issue;
  assign wb_idx    = st_rd;
  assign wb_data   = fmt_data;
  assign upd_en    = st_upd;
  assign upd_idx   = st_ra;
  assign upd_data  = st_ea;
  assign flt_valid = (st_fault != FLT_NONE);
  assign flt_code  = st_fault;

  a_r6_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (!wb_en && !upd_en));
  a_r10_no_read_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (form_bad || align_bad)) |-> !mem_rd_en);
  a_r8_update_pairs_data: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> wb_en);
  a_r9_update_index_legal: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((upd_idx != '0) && (upd_idx != wb_idx)));
  a_r11_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> wb_en);
  a_r4_upper_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && st_size == SZ_HALF && st_sign) |->
      (wb_data[XLEN-1:16] == {(XLEN-16){wb_data[15]}}));
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && st_size == SZ_HALF && !st_sign) |-> (wb_data[XLEN-1:16] == '0));
endmodule

// File: tb/ldf_load_formatter_tb.sv
`timescale 1ns/1ps
module ldf_load_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [1:0]  req_size = '0;
  logic        req_sign = 1'b0;
  logic        req_update = 1'b0;
  logic [4:0]  req_rd = '0;
  logic [4:0]  req_ra = '0;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        wb_en, upd_en, flt_valid;
  logic [4:0]  wb_idx, upd_idx;
  logic [31:0] wb_data, upd_data;
  logic [1:0]  flt_code;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ldf_load_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_disp(req_disp), .req_size(req_size), .req_sign(req_sign),
    .req_update(req_update), .req_rd(req_rd), .req_ra(req_ra),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .flt_valid(flt_valid), .flt_code(flt_code)
  );

  // Memory content: each byte is a function of its own address.
  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'd19;
  endfunction

  always @(posedge clk)
    if (mem_rd_en)
      mem_rdata <= {mbyte(mem_addr), mbyte(mem_addr + 1), mbyte(mem_addr + 2), mbyte(mem_addr + 3)};

  function automatic logic [31:0] ea_calc(input logic [31:0] b, input logic [15:0] d);
    return b + {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] expect_data(input logic [31:0] a, input int sz, input logic sg);
    logic [15:0] h;
    h = {mbyte(a), mbyte(a + 1)};
    if (sz == 0) return {24'd0, mbyte(a)};
    if (sz == 1) return sg ? {{16{h[15]}}, h} : {16'd0, h};
    return {mbyte(a), mbyte(a + 1), mbyte(a + 2), mbyte(a + 3)};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [15:0] d, input int sz,
                       input logic sg, input logic up, input int rd, input int ra);
    req_valid  = 1'b1;
    req_base   = b;
    req_disp   = d;
    req_size   = 2'(sz);
    req_sign   = sg;
    req_update = up;
    req_rd     = 5'(rd);
    req_ra     = 5'(ra);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_sign = 1'b0; req_update = 1'b0;
  endtask

  // Legal load, checked one cycle later.
  task automatic do_load(input string req, input logic [31:0] b, input logic [15:0] d,
                         input int sz, input logic sg, input logic up, input int rd, input int ra);
    logic [31:0] ea;
    ea = ea_calc(b, d);
    @(negedge clk);
    drive(b, d, sz, sg, up, rd, ra);
    #1;
    chk(mem_rd_en === 1'b1, {req, " read strobe"}, 32'(mem_rd_en), 32'd1);
    chk(mem_addr === {ea[31:2], 2'b00}, {req, " read address"}, mem_addr, {ea[31:2], 2'b00});
    @(negedge clk);
    idle();
    chk(wb_en === 1'b1 && wb_idx === 5'(rd), {req, " write enable/index"}, {27'd0, wb_idx}, 32'(rd));
    chk(wb_data === expect_data(ea, sz, sg), {req, " data"}, wb_data, expect_data(ea, sz, sg));
    chk(flt_valid === 1'b0, {req, " no fault"}, 32'(flt_valid), 32'd0);
    if (up) begin
      chk(upd_en === 1'b1 && upd_idx === 5'(ra), {req, " update index"}, {27'd0, upd_idx}, 32'(ra));
      chk(upd_data === ea, {req, " update address"}, upd_data, ea);
    end else
      chk(upd_en === 1'b0, {req, " no update"}, 32'(upd_en), 32'd0);
  endtask

  task automatic do_reject(input string req, input logic [31:0] b, input logic [15:0] d,
                           input int sz, input logic sg, input logic up, input int rd,
                           input int ra, input int code);
    @(negedge clk);
    drive(b, d, sz, sg, up, rd, ra);
    #1;
    chk(mem_rd_en === 1'b0, {req, " no read"}, 32'(mem_rd_en), 32'd0);
    @(negedge clk);
    idle();
    chk(flt_valid === 1'b1 && flt_code === 2'(code), {req, " fault code"}, {30'd0, flt_code}, 32'(code));
    chk(wb_en === 1'b0 && upd_en === 1'b0, {req, " no write"}, {30'd0, wb_en, upd_en}, 32'd0);
    @(negedge clk);
    chk(flt_valid === 1'b0, {req, " fault one cycle"}, 32'(flt_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(wb_en === 1'b0 && upd_en === 1'b0 && flt_valid === 1'b0, "R11 reset outputs",
        {29'd0, wb_en, upd_en, flt_valid}, 32'd0);
  endtask

  task automatic t_ea();
    do_load("R1 positive disp", 32'h0000_1000, 16'h0024, 2, 1'b0, 1'b0, 3, 4);
    do_load("R1 negative disp", 32'h0000_1140, 16'hFEE0, 2, 1'b0, 1'b0, 3, 4);
    do_load("R1 wrap", 32'hFFFF_FFF0, 16'h0018, 0, 1'b0, 1'b0, 3, 4);
  endtask

  task automatic t_byte();
    for (int k = 0; k < 8; k++)
      do_load("R2 byte lane", 32'h0000_2000, 16'(k), 0, 1'b0, 1'b0, 7, 2);
  endtask

  task automatic t_half_zero();
    for (int k = 0; k < 12; k += 2)
      do_load("R3 half zero", 32'h0000_3010, 16'(k), 1, 1'b0, 1'b0, 8, 2);
  endtask

  task automatic t_half_alg();
    for (int k = 0; k < 40; k += 2)
      do_load("R4 half sign", 32'h0000_3000, 16'(k), 1, 1'b1, 1'b0, 9, 2);
  endtask

  task automatic t_word();
    do_load("R5 word", 32'h0000_4000, 16'h0008, 2, 1'b0, 1'b0, 10, 2);
    do_load("R5 word 2", 32'h0000_4100, 16'hFFFC, 2, 1'b0, 1'b0, 11, 2);
  endtask

  task automatic t_form();
    do_reject("R6 signed byte", 32'h100, 16'h0001, 0, 1'b1, 1'b0, 3, 4, 1);
    do_reject("R6 signed word", 32'h100, 16'h0004, 2, 1'b1, 1'b0, 3, 4, 1);
    do_reject("R7 reserved size", 32'h100, 16'h0000, 3, 1'b0, 1'b0, 3, 4, 1);
  endtask

  task automatic t_update();
    do_load("R8 update byte", 32'h0000_5000, 16'h0003, 0, 1'b0, 1'b1, 12, 13);
    do_load("R8 update half neg", 32'h0000_5100, 16'hFFF2, 1, 1'b1, 1'b1, 14, 15);
  endtask

  task automatic t_update_bad();
    do_reject("R9 base zero", 32'h200, 16'h0004, 2, 1'b0, 1'b1, 3, 0, 1);
    do_reject("R9 base equals dest", 32'h200, 16'h0004, 2, 1'b0, 1'b1, 6, 6, 1);
  endtask

  task automatic t_align();
    do_reject("R10 odd half", 32'h300, 16'h0001, 1, 1'b0, 1'b0, 3, 4, 2);
    do_reject("R10 word off 2", 32'h300, 16'h0002, 2, 1'b0, 1'b0, 3, 4, 2);
    do_reject("R10 word off 1", 32'h300, 16'h0001, 2, 1'b0, 1'b0, 3, 4, 2);
    do_reject("R10 priority", 32'h300, 16'h0003, 2, 1'b1, 1'b0, 3, 4, 1);
  endtask

  task automatic t_back2back();
    logic [31:0] ea1, ea2;
    ea1 = ea_calc(32'h600, 16'h0005);
    ea2 = ea_calc(32'h600, 16'h000A);
    @(negedge clk);
    drive(32'h600, 16'h0005, 0, 1'b0, 1'b0, 20, 1);
    @(negedge clk);
    chk(wb_en === 1'b1 && wb_data === expect_data(ea1, 0, 1'b0), "R11 first of pair",
        wb_data, expect_data(ea1, 0, 1'b0));
    drive(32'h600, 16'h000A, 1, 1'b1, 1'b0, 21, 1);
    @(negedge clk);
    idle();
    chk(wb_en === 1'b1 && wb_idx === 5'd21 && wb_data === expect_data(ea2, 1, 1'b1),
        "R11 second of pair", wb_data, expect_data(ea2, 1, 1'b1));
    @(negedge clk);
    chk(wb_en === 1'b0, "R11 single pulse", 32'(wb_en), 32'd0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ea();
    t_byte();
    t_half_zero();
    t_half_alg();
    t_word();
    t_form();
    t_update();
    t_update_bad();
    t_align();
    t_back2back();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule